// File: doc/BRIEF.md
# Interrupt destination matcher

This block decides which local agents an interrupt message is aimed at. For each message it takes an 8-bit destination, a bit that picks physical or logical addressing, a 2-bit shorthand, the index of the sending agent and a 3-bit delivery mode. From these it forms a bitmask with one bit per agent. Each agent supplies its physical ID, its 8-bit logical ID, a 4-bit addressing model and a present flag. The model is chosen per agent, so flat and cluster agents can share one system.

For lowest-priority delivery the block also reduces the mask to a single one-hot target, which is the lowest-indexed agent in the mask. The match logic is purely combinational and feeds one output register, so results appear one clock after the inputs are sampled. The block does not hold agent configuration and does not deliver messages. Its user feeds agent state in and forwards the mask.

Top module: `intr_dest_match`

## Requirements
- R1: While rst_ni is low, and until the first rising edge after it rises, target_mask_o and single_o are all zero.
- R2: With shorthand 2'd0 and logical_i low, destination 8'hFF selects every present agent.
- R3: With shorthand 2'd0, logical_i low and any destination other than 8'hFF, the agents selected are those whose physical ID equals the destination. If no agent's ID matches, the mask is zero.
- R4: With shorthand 2'd0 and logical_i high, an agent with model 4'hF (flat) is selected when the bitwise AND of the destination and its logical ID is nonzero.
- R5: With shorthand 2'd0 and logical_i high, an agent with model 4'h0 (cluster) is selected when the upper nibbles of the destination and its logical ID are equal and their lower nibbles share at least one set bit.
- R6: In logical addressing, an agent whose model is neither 4'hF nor 4'h0 is never selected.
- R7: An agent left in its reset configuration (logical ID 8'h00, model 4'hF) matches no logical destination.
- R8: The shorthand is decoded as follows: 2'd1 selects only the sender, 2'd2 selects all agents, and 2'd3 selects all agents except the sender. In these cases the destination and logical_i are ignored.
- R9: An agent whose present_i bit is low never appears in target_mask_o or single_o.
- R10: When dmode_i is 3'd1 (lowest priority), single_o is the lowest set bit of target_mask_o, or zero if the mask is empty. For any other mode single_o is zero. In both cases target_mask_o holds the full mask.
- R11: The outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dest_i | input | ID_W | Destination field of the message |
| logical_i | input | 1 | 1 = logical addressing, 0 = physical |
| shorthand_i | input | 2 | Destination shorthand |
| sender_i | input | $clog2(N_AGENTS) | Index of the sending agent |
| dmode_i | input | 3 | Delivery mode; 3'd1 is lowest priority |
| present_i | input | N_AGENTS | Agent present flags |
| phys_id_i | input | N_AGENTS*ID_W | Packed physical IDs, agent 0 in the low bits |
| log_id_i | input | N_AGENTS*ID_W | Packed logical IDs, agent 0 in the low bits |
| model_i | input | N_AGENTS*4 | Packed addressing models, agent 0 in the low bits |
| target_mask_o | output | N_AGENTS | Registered target bitmask |
| single_o | output | N_AGENTS | Registered one-hot lowest-priority target |

## Verification
The assertions assume that every input is known (not X) at each rising edge and that sender_i addresses an agent that exists. They also assume that the outputs are read only after a full clock cycle. The stimulus drives all inputs on the falling edge from fully defined values, with sender_i drawn from 0 to N_AGENTS-1. Physical IDs are drawn from a small pool so that duplicate and missing IDs both occur. The models mix flat, cluster and illegal values, and the present flags are randomly cleared.

// File: rtl/intr_match_pkg.sv
package intr_match_pkg;
  typedef enum logic [1:0] {
    SH_DEST   = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  localparam int          MODEL_W       = 4;
  localparam logic [3:0]  MODEL_FLAT    = 4'hF;
  localparam logic [3:0]  MODEL_CLUSTER = 4'h0;
  localparam logic [2:0]  DM_LOWEST     = 3'd1;
endpackage

// File: rtl/agent_match.sv
module agent_match
  import intr_match_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0]    dest_i,
  input  logic               logical_i,
  input  logic [ID_W-1:0]    phys_id_i,
  input  logic [ID_W-1:0]    log_id_i,
  input  logic [MODEL_W-1:0] model_i,
  output logic               hit_o
);
  localparam int HALF = ID_W / 2;

  logic phys_hit, flat_hit, clus_hit;

  always_comb begin
    phys_hit = (dest_i == {ID_W{1'b1}}) || (dest_i == phys_id_i);
    flat_hit = (model_i == MODEL_FLAT) && ((dest_i & log_id_i) != '0);
    clus_hit = (model_i == MODEL_CLUSTER)
            && (dest_i[ID_W-1:HALF] == log_id_i[ID_W-1:HALF])
            && ((dest_i[HALF-1:0] & log_id_i[HALF-1:0]) != '0);
    hit_o    = logical_i ? (flat_hit | clus_hit) : phys_hit;
  end
endmodule

// File: rtl/shorthand_sel.sv
module shorthand_sel
  import intr_match_pkg::*;
#(
  parameter int N_AGENTS = 16,
  localparam int IDX_W   = $clog2(N_AGENTS)
) (
  input  logic [N_AGENTS-1:0] hit_i,
  input  logic [N_AGENTS-1:0] present_i,
  input  logic [1:0]          shorthand_i,
  input  logic [IDX_W-1:0]    sender_i,
  output logic [N_AGENTS-1:0] mask_o
);
  logic [N_AGENTS-1:0] self_vec;
  logic [N_AGENTS-1:0] raw;

  always_comb begin
    self_vec = '0;
    for (int i = 0; i < N_AGENTS; i++)
      self_vec[i] = (sender_i == IDX_W'(i));
    case (shorthand_e'(shorthand_i))
      SH_SELF:   raw = self_vec;
      SH_ALL:    raw = '1;
      SH_OTHERS: raw = ~self_vec;
      default:   raw = hit_i;
    endcase
    mask_o = raw & present_i;
  end
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int N_AGENTS = 16
) (
  input  logic [N_AGENTS-1:0] mask_i,
  output logic [N_AGENTS-1:0] pick_o
);
  logic [N_AGENTS:0] seen;

  assign seen[0] = 1'b0;
  for (genvar g = 0; g < N_AGENTS; g++) begin : g_chain
    assign pick_o[g]   = mask_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | mask_i[g];
  end
endmodule

// File: rtl/intr_dest_match.sv
module intr_dest_match
  import intr_match_pkg::*;
#(
  parameter int N_AGENTS = 16,
  parameter int ID_W     = 8,
  localparam int IDX_W   = $clog2(N_AGENTS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ID_W-1:0]            dest_i,
  input  logic                       logical_i,
  input  logic [1:0]                 shorthand_i,
  input  logic [IDX_W-1:0]           sender_i,
  input  logic [2:0]                 dmode_i,
  input  logic [N_AGENTS-1:0]        present_i,
  input  logic [N_AGENTS*ID_W-1:0]   phys_id_i,
  input  logic [N_AGENTS*ID_W-1:0]   log_id_i,
  input  logic [N_AGENTS*MODEL_W-1:0] model_i,
  output logic [N_AGENTS-1:0]        target_mask_o,
  output logic [N_AGENTS-1:0]        single_o
);
  logic [N_AGENTS-1:0] hit;
  logic [N_AGENTS-1:0] mask_d;
  logic [N_AGENTS-1:0] pick;
  logic [N_AGENTS-1:0] single_d;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    agent_match #(.ID_W(ID_W)) u_match (
      .dest_i    (dest_i),
      .logical_i (logical_i),
      .phys_id_i (phys_id_i[g*ID_W +: ID_W]),
      .log_id_i  (log_id_i[g*ID_W +: ID_W]),
      .model_i   (model_i[g*MODEL_W +: MODEL_W]),
      .hit_o     (hit[g])
    );
  end

  shorthand_sel #(.N_AGENTS(N_AGENTS)) u_sel (
    .hit_i       (hit),
    .present_i   (present_i),
    .shorthand_i (shorthand_i),
    .sender_i    (sender_i),
    .mask_o      (mask_d)
  );

  lowest_pick #(.N_AGENTS(N_AGENTS)) u_pick (
    .mask_i (mask_d),
    .pick_o (pick)
  );

  assign single_d = (dmode_i == DM_LOWEST) ? pick : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_mask_o <= '0;
      single_o      <= '0;
    end else begin
      target_mask_o <= mask_d;
      single_o      <= single_d;
    end
  end
endmodule

// File: rtl/intr_dest_match_chk.sv
module intr_dest_match_chk #(
  parameter int N_AGENTS = 16,
  localparam int IDX_W   = $clog2(N_AGENTS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          shorthand_i,
  input logic [IDX_W-1:0]    sender_i,
  input logic [2:0]          dmode_i,
  input logic [N_AGENTS-1:0] present_i,
  input logic [N_AGENTS-1:0] target_mask_o,
  input logic [N_AGENTS-1:0] single_o
);
  localparam logic [N_AGENTS-1:0] ONE = N_AGENTS'(1);

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (target_mask_o == '0 && single_o == '0));

  // R9
  absent_never_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((target_mask_o | single_o) & ~$past(present_i)) == '0);

  // R8
  all_shorthand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shorthand_i == 2'd2) |=> target_mask_o == $past(present_i));

  // R8
  self_shorthand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shorthand_i == 2'd1) |=> (target_mask_o & ~(ONE << $past(sender_i))) == '0);

  // R8
  others_shorthand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shorthand_i == 2'd3) |=> (target_mask_o & (ONE << $past(sender_i))) == '0);

  // R10
  single_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(single_o) && ((single_o & ~target_mask_o) == '0));

  // R10
  single_needs_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmode_i != 3'd1) |=> single_o == '0);

  // R10
  single_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmode_i == 3'd1) |=> ((target_mask_o != '0) == (single_o != '0)));
endmodule

bind intr_dest_match intr_dest_match_chk #(.N_AGENTS(N_AGENTS)) u_chk (.*);

// File: tb/intr_dest_match_tb.sv
`timescale 1ns/1ps
module intr_dest_match_tb;
  localparam int N = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    dest_i = '0;
  logic          logical_i = 1'b0;
  logic [1:0]    shorthand_i = '0;
  logic [3:0]    sender_i = '0;
  logic [2:0]    dmode_i = '0;
  logic [N-1:0]  present_i;
  logic [N*8-1:0] phys_id_i;
  logic [N*8-1:0] log_id_i;
  logic [N*4-1:0] model_i;
  logic [N-1:0]  target_mask_o;
  logic [N-1:0]  single_o;

  int pid [N];
  int lid [N];
  int mdl [N];
  bit pres [N];

  int checks = 0;
  int fails  = 0;

  always #2 clk_i = ~clk_i;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      present_i[i]        = pres[i];
      phys_id_i[i*8 +: 8] = 8'(pid[i]);
      log_id_i[i*8 +: 8]  = 8'(lid[i]);
      model_i[i*4 +: 4]   = 4'(mdl[i]);
    end
  end

  intr_dest_match u_dut (
    .clk_i, .rst_ni, .dest_i, .logical_i, .shorthand_i, .sender_i,
    .dmode_i, .present_i, .phys_id_i, .log_id_i, .model_i,
    .target_mask_o, .single_o
  );

  function automatic logic [N-1:0] ref_mask(int d, bit lg, int sh, int snd);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      bit m = 0;
      case (sh)
        0: begin
          if (!lg) m = (d == 255) || (pid[i] == d);
          else if (mdl[i] == 15) m = (d & lid[i]) != 0;
          else if (mdl[i] == 0)
            m = ((d >> 4) == (lid[i] >> 4)) && ((d & lid[i] & 15) != 0);
        end
        1: m = (i == snd);
        2: m = 1;
        default: m = (i != snd);
      endcase
      r[i] = m && pres[i];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] ref_single(logic [N-1:0] m, int dm);
    logic [N-1:0] r = '0;
    if (dm == 1)
      for (int i = N - 1; i >= 0; i--) if (m[i]) r = '0 | (N'(1) << i);
    return r;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(string tag, int d, bit lg, int sh, int snd, int dm);
    logic [N-1:0] em;
    @(negedge clk_i);
    dest_i = 8'(d); logical_i = lg; shorthand_i = 2'(sh);
    sender_i = 4'(snd); dmode_i = 3'(dm);
    @(posedge clk_i);
    #1;
    em = ref_mask(d, lg, sh, snd);
    chk({tag, " mask"}, target_mask_o, em);
    chk({tag, " single"}, single_o, ref_single(em, dm));
  endtask

  task automatic cfg_default();
    for (int i = 0; i < N; i++) begin
      pid[i] = i; lid[i] = 0; mdl[i] = 15; pres[i] = 1;
    end
  endtask

  initial begin
    cfg_default();
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 reset mask", target_mask_o, '0);
    chk("R1 reset single", single_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
    chk("R1 after release", target_mask_o, '0);

    // physical
    apply("R2 broadcast", 255, 0, 0, 0, 0);
    apply("R3 exact id", 5, 0, 0, 0, 0);
    apply("R3 no match", 200, 0, 0, 0, 0);
    pid[9] = 5;
    apply("R3 duplicate id", 5, 0, 0, 0, 1);
    // reset-config logical IDs
    apply("R7 reset config", 255, 1, 0, 0, 0);
    // flat
    lid[2] = 8'h01; lid[3] = 8'h82; lid[7] = 8'h40;
    apply("R4 flat", 8'h41, 1, 0, 0, 0);
    apply("R4 flat miss", 8'h04, 1, 0, 0, 0);
    // cluster
    mdl[4] = 0; lid[4] = 8'h35; mdl[5] = 0; lid[5] = 8'h32; mdl[6] = 0; lid[6] = 8'h45;
    apply("R5 cluster", 8'h31, 1, 0, 0, 1);
    apply("R5 cluster wrong upper", 8'h25, 1, 0, 0, 0);
    // illegal model
    mdl[8] = 4'h3; lid[8] = 8'hFF;
    apply("R6 illegal model", 8'hFF, 1, 0, 0, 0);
    // shorthands
    apply("R8 self", 255, 0, 1, 6, 0);
    apply("R8 all", 3, 1, 2, 6, 1);
    apply("R8 others", 0, 0, 3, 0, 1);
    // absent
    pres[0] = 0; pres[6] = 0;
    apply("R9 absent others", 0, 0, 3, 3, 1);
    apply("R9 absent self", 0, 0, 1, 6, 1);
    apply("R9 absent bcast", 255, 0, 0, 0, 1);
    // lowest priority
    apply("R10 lowest empty", 201, 0, 0, 0, 1);
    apply("R10 other mode", 255, 0, 0, 0, 4);
    // latency: hold inputs, change then sample after one edge
    apply("R11 before change", 2, 0, 0, 0, 0);
    apply("R11 after change", 3, 0, 0, 0, 0);

    // random, compared on every clock
    for (int n = 0; n < 600; n++) begin
      int d, sh, k;
      if (n % 20 == 0)
        for (int i = 0; i < N; i++) begin
          pid[i] = $urandom_range(0, 23);
          lid[i] = $urandom_range(0, 255);
          k = $urandom_range(0, 9);
          mdl[i] = (k < 4) ? 15 : (k < 8) ? 0 : $urandom_range(1, 14);
          pres[i] = ($urandom_range(0, 5) != 0);
        end
      k = $urandom_range(0, 3);
      d = (k == 0) ? 255 : (k == 1) ? pid[$urandom_range(0, N-1)]
        : (k == 2) ? lid[$urandom_range(0, N-1)] : $urandom_range(0, 255);
      sh = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 3) : 0;
      apply("R11 random", d, 1'($urandom_range(0, 1)), sh,
            $urandom_range(0, N-1), $urandom_range(0, 7));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule